// File: doc/BRIEF.md
# Packed String Compare Result Finalizer

This block is the final stage of a packed string compare unit. The all-pairs compare and the aggregation step run upstream, and their output reaches this block as a 16-bit match vector. The block combines that vector with the lengths of the two strings and with the instruction's 8-bit immediate. From these it produces the architectural result, which is either a 128-bit mask or a 5-bit element index, together with six arithmetic flags.

The string lengths can come from two sources. In implicit mode, the block scans each 128-bit operand for its first all-zero element. In explicit mode, the block takes each length from a general register value. That value is read as signed in either its 32-bit or its 64-bit form, converted to its magnitude, and capped at the element count.

A request is presented with `in_valid` for one cycle. The result registers load on that edge, and `out_valid` is high for the one cycle that follows.

Top module: `spf_finalize`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_mask`, `out_index` and `out_flags` become zero.
- R2: A request accepted with `in_valid` high shows its result on the outputs after exactly one clock edge, with `out_valid` high for that one cycle. Without `in_valid`, `out_valid` is low and the other outputs hold their values.
- R3: `imm[0]` selects the element size. When it is 1, elements are 16 bits, the count is 8, and `match_vec[15:8]` is ignored (treated as zero) everywhere. When it is 0, elements are bytes and the count is 16.
- R4: With `mode_index`=0 and `imm[6]`=0, `out_mask[15:0]` equals the effective match vector and `out_mask[127:16]` is zero.
- R5: With `mode_index`=0 and `imm[6]`=1, match bit k fills element k of `out_mask` with all ones, or leaves it all zeros. Element k is byte k, or 16-bit word k in word mode.
- R6: With `mode_index`=1, `out_index` is the position of the lowest set effective match bit when `imm[6]`=0, and of the highest set bit when `imm[6]`=1.
- R7: With `mode_index`=1 and no effective match bit set, `out_index` equals the element count (16 or 8).
- R8: The flag vector is laid out as bit0 CF, bit1 PF, bit2 AF, bit3 ZF, bit4 SF, bit5 OF. CF is 1 when the effective vector is non-zero, OF equals effective bit 0, and PF and AF are always 0.
- R9: SF is 1 when the length of string A is below the element count. ZF is 1 when the length of string B is below the element count.
- R10: With `len_explicit`=0, each length is the index of the first all-zero element of `op_a` or `op_b`, with element 0 in the lowest bits. If no element is zero, the length is the element count.
- R11: With `len_explicit`=1, each length is the magnitude of `reg_a` or `reg_b`, capped at the element count. The register is read as a signed 64-bit value when `len_wide`=1, and as signed `[31:0]` with `[63:32]` ignored when `len_wide`=0.
- R12: The form that was not selected is zero: `out_index` is 0 in mask mode and `out_mask` is 0 in index mode. Flags are produced in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| imm | input | 8 | Immediate; bit 0 element size, bit 6 format/direction |
| mode_index | input | 1 | 1 selects index form, 0 mask form |
| len_explicit | input | 1 | 1 takes lengths from registers, 0 scans operands |
| len_wide | input | 1 | 1 reads registers as 64-bit, 0 as 32-bit |
| op_a | input | 128 | Operand A for implicit length |
| op_b | input | 128 | Operand B for implicit length |
| reg_a | input | 64 | Length register for string A |
| reg_b | input | 64 | Length register for string B |
| match_vec | input | 16 | Aggregated match vector |
| out_valid | output | 1 | Result strobe |
| out_mask | output | 128 | Mask form result |
| out_index | output | 5 | Index form result |
| out_flags | output | 6 | Flags {OF,SF,ZF,AF,PF,CF} |

## Verification
Length detection and the index search can both reach the element-count boundary in the same request. One such case is an empty match vector, which makes the index equal the count, arriving together with lengths that sit exactly at the count or one below it. The bench provokes this by placing zero elements at chosen positions, and by presenting register values that are negative or beyond the count in both register widths. For each request, the bench compares the index, SF and ZF against values it derives independently from the requirements. Word mode is run with junk in the upper match bits, so that a leak of those bits into CF, the index or the mask is caught.

// File: rtl/spf_pkg.sv
// Shared sizes and flag bit positions for the string compare finalizer.
// Assumes a 128-bit operand and a 16-bit match vector.
package spf_pkg;
    localparam int unsigned DATA_W     = 128;
    localparam int unsigned REG_W      = 64;
    localparam int unsigned NARROW_W   = 32;
    localparam int unsigned BYTE_LANES = DATA_W / 8;
    localparam int unsigned WORD_LANES = DATA_W / 16;
    localparam int unsigned CNT_W      = $clog2(BYTE_LANES) + 1;
    localparam int unsigned FLAG_W     = 6;
    localparam int unsigned FL_CF = 0;
    localparam int unsigned FL_PF = 1;
    localparam int unsigned FL_AF = 2;
    localparam int unsigned FL_ZF = 3;
    localparam int unsigned FL_SF = 4;
    localparam int unsigned FL_OF = 5;
endpackage

// File: rtl/spf_zero_scan.sv
// Implicit length: the index of the first all-zero element of an operand,
// or the element count when no element is zero. Element 0 is the lowest bits.
module spf_zero_scan
    import spf_pkg::*;
(
    input  logic [DATA_W-1:0] opnd,
    input  logic              word_mode,
    output logic [CNT_W-1:0]  len
);
    logic [BYTE_LANES-1:0] byte_zero;
    logic [WORD_LANES-1:0] word_zero;

    genvar g;
    generate
        for (g = 0; g < BYTE_LANES; g++) begin : g_byte
            assign byte_zero[g] = (opnd[g*8 +: 8] == 8'h00);
        end
        for (g = 0; g < WORD_LANES; g++) begin : g_word
            assign word_zero[g] = (opnd[g*16 +: 16] == 16'h0000);
        end
    endgenerate

    // Pick the lowest zero element for the active element size.
    always_comb begin
        if (word_mode) begin
            len = CNT_W'(WORD_LANES);
            for (int i = WORD_LANES - 1; i >= 0; i--)
                if (word_zero[i]) len = CNT_W'(i);
        end else begin
            len = CNT_W'(BYTE_LANES);
            for (int i = BYTE_LANES - 1; i >= 0; i--)
                if (byte_zero[i]) len = CNT_W'(i);
        end
    end
endmodule

// File: rtl/spf_len_clamp.sv
// Explicit length: magnitude of a signed register value, capped at the
// element count. Narrow form reads only the low 32 bits as signed.
module spf_len_clamp
    import spf_pkg::*;
(
    input  logic [REG_W-1:0] raw,
    input  logic             wide,
    input  logic             word_mode,
    output logic [CNT_W-1:0] len
);
    logic [REG_W-1:0] val;
    logic [REG_W-1:0] mag;
    logic [CNT_W-1:0] limit;

    // Sign-extend the chosen register form and take its magnitude.
    always_comb begin
        if (wide) val = raw;
        else      val = {{(REG_W-NARROW_W){raw[NARROW_W-1]}}, raw[NARROW_W-1:0]};
        mag = val[REG_W-1] ? (~val + 1'b1) : val;
    end

    // Cap the magnitude at the element count.
    always_comb begin
        limit = word_mode ? CNT_W'(WORD_LANES) : CNT_W'(BYTE_LANES);
        if (mag >= {{(REG_W-CNT_W){1'b0}}, limit}) len = limit;
        else                                        len = mag[CNT_W-1:0];
    end
endmodule

// File: rtl/spf_result_fmt.sv
// Builds the mask or index form and the flags from the match vector and the
// two lengths. In word mode the upper eight match bits are discarded.
module spf_result_fmt
    import spf_pkg::*;
(
    input  logic [BYTE_LANES-1:0] vec,
    input  logic                  word_mode,
    input  logic                  alt_sel,
    input  logic                  index_mode,
    input  logic [CNT_W-1:0]      len_a,
    input  logic [CNT_W-1:0]      len_b,
    output logic [DATA_W-1:0]     mask,
    output logic [CNT_W-1:0]      index,
    output logic [FLAG_W-1:0]     flags
);
    logic [BYTE_LANES-1:0] eff;
    logic [CNT_W-1:0]      count;
    logic [DATA_W-1:0]     exp_byte;
    logic [DATA_W-1:0]     exp_word;
    logic [CNT_W-1:0]      low_pos;
    logic [CNT_W-1:0]      high_pos;

    assign eff   = word_mode ? {{(BYTE_LANES-WORD_LANES){1'b0}}, vec[WORD_LANES-1:0]} : vec;
    assign count = word_mode ? CNT_W'(WORD_LANES) : CNT_W'(BYTE_LANES);

    genvar g;
    generate
        for (g = 0; g < BYTE_LANES; g++) begin : g_xb
            assign exp_byte[g*8 +: 8] = {8{eff[g]}};
        end
        for (g = 0; g < WORD_LANES; g++) begin : g_xw
            assign exp_word[g*16 +: 16] = {16{eff[g]}};
        end
    endgenerate

    // Lowest and highest set positions, defaulting to the element count.
    always_comb begin
        low_pos  = count;
        high_pos = count;
        for (int i = BYTE_LANES - 1; i >= 0; i--)
            if (eff[i]) low_pos = CNT_W'(i);
        for (int i = 0; i < BYTE_LANES; i++)
            if (eff[i]) high_pos = CNT_W'(i);
    end

    // Select the result form; the unused form is zero.
    always_comb begin
        mask  = '0;
        index = '0;
        if (index_mode)   index = alt_sel ? high_pos : low_pos;
        else if (alt_sel) mask  = word_mode ? exp_word : exp_byte;
        else              mask  = {{(DATA_W-BYTE_LANES){1'b0}}, eff};
    end

    // Flags from the vector and the two lengths.
    always_comb begin
        flags        = '0;
        flags[FL_CF] = |eff;
        flags[FL_OF] = eff[0];
        flags[FL_SF] = (len_a < count);
        flags[FL_ZF] = (len_b < count);
    end
endmodule

// File: rtl/spf_finalize.sv
// Top of the string compare finalizer: selects implicit or explicit lengths,
// formats the result and registers it for one cycle of out_valid.
// Assumes one request per in_valid pulse; outputs hold between requests.
module spf_finalize
    import spf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [7:0]   imm,
    input  logic         mode_index,
    input  logic         len_explicit,
    input  logic         len_wide,
    input  logic [127:0] op_a,
    input  logic [127:0] op_b,
    input  logic [63:0]  reg_a,
    input  logic [63:0]  reg_b,
    input  logic [15:0]  match_vec,
    output logic         out_valid,
    output logic [127:0] out_mask,
    output logic [4:0]   out_index,
    output logic [5:0]   out_flags
);
    logic              word_mode;
    logic [CNT_W-1:0]  imp_a, imp_b, exp_a, exp_b, len_a, len_b;
    logic [DATA_W-1:0] nxt_mask;
    logic [CNT_W-1:0]  nxt_index;
    logic [FLAG_W-1:0] nxt_flags;

    assign word_mode = imm[0];

    spf_zero_scan u_scan_a (.opnd(op_a), .word_mode(word_mode), .len(imp_a));
    spf_zero_scan u_scan_b (.opnd(op_b), .word_mode(word_mode), .len(imp_b));

    spf_len_clamp u_clamp_a (.raw(reg_a), .wide(len_wide), .word_mode(word_mode), .len(exp_a));
    spf_len_clamp u_clamp_b (.raw(reg_b), .wide(len_wide), .word_mode(word_mode), .len(exp_b));

    assign len_a = len_explicit ? exp_a : imp_a;
    assign len_b = len_explicit ? exp_b : imp_b;

    spf_result_fmt u_fmt (
        .vec(match_vec), .word_mode(word_mode), .alt_sel(imm[6]),
        .index_mode(mode_index), .len_a(len_a), .len_b(len_b),
        .mask(nxt_mask), .index(nxt_index), .flags(nxt_flags)
    );

    // Result registers: load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_index <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask  <= nxt_mask;
                out_index <= nxt_index;
                out_flags <= nxt_flags;
            end
        end
    end
endmodule

// File: rtl/spf_finalize_chk.sv
// Port-level checker for spf_finalize, attached by bind below.
module spf_finalize_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [7:0]   imm,
    input logic         mode_index,
    input logic [15:0]  match_vec,
    input logic         out_valid,
    input logic [127:0] out_mask,
    input logic [4:0]   out_index,
    input logic [5:0]   out_flags
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_PACKED_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_index && !imm[6]) |=> (out_mask[127:16] == 112'd0)); // R4
    AST_EMPTY_BYTE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_index && !imm[0] && match_vec == 16'd0) |=> (out_index == 5'd16)); // R7
    AST_EMPTY_WORD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_index && imm[0] && match_vec[7:0] == 8'd0) |=> (out_index == 5'd8)); // R7
    AST_OF_IMPLIES_CF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[5]) |-> out_flags[0]); // R8
    AST_PF_AF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flags[2:1] == 2'b00)); // R8
    AST_INDEX_FORM_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_index) |=> (out_mask == 128'd0)); // R12
    AST_MASK_FORM_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_index) |=> (out_index == 5'd0)); // R12
endmodule

bind spf_finalize spf_finalize_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm(imm),
    .mode_index(mode_index), .match_vec(match_vec), .out_valid(out_valid),
    .out_mask(out_mask), .out_index(out_index), .out_flags(out_flags)
);

// File: tb/spf_finalize_tb.sv
module spf_finalize_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   imm = '0;
    logic         mode_index = 1'b0;
    logic         len_explicit = 1'b0;
    logic         len_wide = 1'b0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic [63:0]  reg_a = '0;
    logic [63:0]  reg_b = '0;
    logic [15:0]  match_vec = '0;
    logic         out_valid;
    logic [127:0] out_mask;
    logic [4:0]   out_index;
    logic [5:0]   out_flags;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spf_finalize u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm(imm),
        .mode_index(mode_index), .len_explicit(len_explicit), .len_wide(len_wide),
        .op_a(op_a), .op_b(op_b), .reg_a(reg_a), .reg_b(reg_b),
        .match_vec(match_vec), .out_valid(out_valid), .out_mask(out_mask),
        .out_index(out_index), .out_flags(out_flags)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Reference length from the requirements.
    function automatic int ref_impl(input logic [127:0] op, input bit word);
        int n = word ? 8 : 16;
        int w = word ? 16 : 8;
        for (int k = 0; k < n; k++) begin
            logic [127:0] s = op >> (k * w);
            if ((word ? s[15:0] : {8'h00, s[7:0]}) == 16'h0000) return k;
        end
        return n;
    endfunction

    function automatic int ref_expl(input logic [63:0] r, input bit wide, input bit word);
        logic signed [64:0] s;
        logic signed [64:0] m;
        int n = word ? 8 : 16;
        s = wide ? $signed({r[63], r}) : $signed({{33{r[31]}}, r[31:0]});
        m = (s < 0) ? -s : s;
        return (m > n) ? n : int'(m);
    endfunction

    // Apply one request, then sample one edge later away from the edge.
    task automatic run(input string tag, input logic [7:0] im, input bit idx,
                       input bit expl, input bit wide,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic [63:0] ra, input logic [63:0] rb,
                       input logic [15:0] mv);
        int n, la, lb, lo, hi;
        logic [15:0] e;
        logic [127:0] xm;
        logic [5:0] xf;
        bit word;
        word = im[0];
        n = word ? 8 : 16;
        e = word ? {8'h00, mv[7:0]} : mv;
        la = expl ? ref_expl(ra, wide, word) : ref_impl(a, word);
        lb = expl ? ref_expl(rb, wide, word) : ref_impl(b, word);
        lo = n; hi = n;
        for (int k = 0; k < n; k++) if (e[k]) begin hi = k; if (lo == n) lo = k; end
        xm = '0;
        if (!idx) begin
            if (!im[6]) xm[15:0] = e;
            else for (int k = 0; k < n; k++)
                if (e[k]) begin
                    if (word) xm[k*16 +: 16] = 16'hFFFF;
                    else      xm[k*8 +: 8] = 8'hFF;
                end
        end
        xf = {e[0], la < n, lb < n, 1'b0, 1'b0, e != 16'h0};
        @(negedge clk);
        imm = im; mode_index = idx; len_explicit = expl; len_wide = wide;
        op_a = a; op_b = b; reg_a = ra; reg_b = rb; match_vec = mv; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid R2"}, {127'd0, out_valid}, 128'd1);
        check({tag, " mask"}, out_mask, xm);
        check({tag, " index"}, {123'd0, out_index}, idx ? 128'(im[6] ? hi : lo) : 128'd0);
        check({tag, " flags"}, {122'd0, out_flags}, {122'd0, xf});
    endtask

    localparam logic [127:0] NOZ = {16{8'h41}};

    task automatic t_reset();
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 mask", out_mask, 128'd0);
        check("R1 index", {123'd0, out_index}, 128'd0);
        check("R1 flags", {122'd0, out_flags}, 128'd0);
    endtask

    task automatic t_mask_forms();
        logic [127:0] a5 = NOZ;
        a5[47:40] = 8'h00;
        run("R4 R10 packed byte", 8'h00, 0, 0, 0, a5, NOZ, 0, 0, 16'hA5C3);
        run("R5 expand byte", 8'h40, 0, 0, 0, NOZ, a5, 0, 0, 16'h8001);
        run("R3 R5 expand word junk-high", 8'h41, 0, 0, 0, NOZ, NOZ, 0, 0, 16'hFF24);
        run("R3 R4 packed word junk-high", 8'h01, 0, 0, 0, a5, NOZ, 0, 0, 16'hF0F1);
    endtask

    task automatic t_index();
        run("R6 lsb byte", 8'h00, 1, 0, 0, NOZ, NOZ, 0, 0, 16'h0C30);
        run("R6 msb byte", 8'h40, 1, 0, 0, NOZ, NOZ, 0, 0, 16'h0C31);
        run("R6 R3 msb word", 8'h41, 1, 0, 0, NOZ, NOZ, 0, 0, 16'hFF12);
        run("R6 R3 lsb word", 8'h01, 1, 0, 0, NOZ, NOZ, 0, 0, 16'h0180);
    endtask

    task automatic t_empty_boundary();
        logic [127:0] a15 = NOZ;
        logic [127:0] w7 = NOZ;
        a15[127:120] = 8'h00;
        w7[127:112] = 16'h0000;
        run("R7 R9 empty byte", 8'h00, 1, 0, 0, a15, 128'd0, 0, 0, 16'h0000);
        run("R7 R9 empty word", 8'h41, 1, 0, 0, NOZ, w7, 0, 0, 16'hFF00);
        run("R8 R10 all zero ops", 8'h00, 0, 0, 0, 128'd0, 128'd0, 0, 0, 16'h0001);
    endtask

    task automatic t_explicit();
        run("R11 narrow neg", 8'h00, 1, 1, 0, NOZ, NOZ, 64'hFFFF_FFFF_FFFF_FFFB, 64'd16, 16'h0100);
        run("R11 narrow ignores upper", 8'h00, 1, 1, 0, NOZ, NOZ, 64'hFFFF_FFFF_0000_0003, 64'h8000_0000_0000_0010, 16'h0002);
        run("R11 wide neg sat", 8'h00, 0, 1, 1, NOZ, NOZ, 64'hFFFF_FFFF_0000_0003, 64'h0000_0000_8000_0000, 16'h1234);
        run("R11 wide most-neg", 8'h01, 1, 1, 1, NOZ, NOZ, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFF9, 16'h0040);
        run("R11 narrow most-neg word", 8'h01, 0, 1, 0, NOZ, NOZ, 64'h0000_0000_8000_0000, 64'd8, 16'h0003);
    endtask

    task automatic t_hold();
        logic [127:0] m;
        m = out_mask;
        @(negedge clk);
        match_vec = 16'hFFFF; imm = 8'h40;
        @(negedge clk);
        check("R2 idle valid", {127'd0, out_valid}, 128'd0);
        check("R2 idle hold", out_mask, m);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mask_forms();
        t_index();
        t_empty_boundary();
        t_explicit();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule